// File: doc/BRIEF.md
# Memory-Mapped 64-bit Machine Timer

This block keeps a 64-bit system time that advances by one on every clock in which the tick enable is high, and a 64-bit compare value. Software reaches both through four 32-bit words on a small word-addressed register port. Writes land on the clock edge. Reads are combinational on the address.

The timer interrupt output is a plain level. It is high whenever the full unsigned 64-bit time is greater than or equal to the full 64-bit compare value. It falls only once software rewrites the time or the compare value so that time is below compare. A read-only copy of the time feeds the CPU's time counters.

A build parameter can leave the unit out. In that case the interrupt is taken straight from an external pin.

Top module: `sys_timer64`

## Requirements
- R1: After reset the time and the compare value are both zero, so the interrupt output is high (0 >= 0).
- R2: While `tick_en` is high and no time word is written, the 64-bit time increases by exactly one per clock. While `tick_en` is low and no time word is written, the time holds.
- R3: When the low time word is all ones and an increment occurs, the low word becomes zero and the high word increases by one on that same edge.
- R4: A write to either time word takes priority over the increment in that cycle. The written half takes the write data, and the other half keeps its previous value.
- R5: The compare value changes only through writes to its two words. Each word write replaces only that half.
- R6: `tmr_irq` is high exactly when {time_hi,time_lo} >= {cmp_hi,cmp_lo}, compared unsigned over all 64 bits. This includes cases decided only by the high word.
- R7: Once asserted, the interrupt stays high until a write to a time or compare word makes time less than compare.
- R8: `time_now` always equals the current 64-bit time.
- R9: Word map on `addr`: 0 = time low, 1 = time high, 2 = compare low, 3 = compare high. `rd_data` shows the addressed word in the same cycle.
- R10: With `PRESENT` = 0, `tmr_irq` follows `ext_irq`, and both `rd_data` and `time_now` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time increment enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed word |
| ext_irq | input | 1 | Interrupt source used when the unit is absent |
| time_now | output | 64 | Current time for the CPU time counters |
| tmr_irq | output | 1 | Level machine timer interrupt |

## Verification
The two functions that can meet in one cycle are a software write to a time word and the hardware increment, including the increment that carries across the word boundary. The bench keeps `tick_en` high through a write cycle. It then checks that the written half holds exactly the write data and that the other half is unincremented. It also presets the low word to all ones and checks that both words step on the same edge. The comparator is swept over a grid of high/low values for time and compare, and each result is judged against an arithmetic 64-bit comparison.

// File: rtl/sys_timer64.sv
module sys_timer64 #(
  parameter bit PRESENT = 1'b1,
  parameter int DW      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            ext_irq,
  output logic [2*DW-1:0] time_now,
  output logic            tmr_irq
);
  localparam int TW = 2 * DW;

  if (PRESENT) begin : g_timer
    logic [DW-1:0] t_lo, t_hi, c_lo, c_hi;
    logic [TW-1:0] t_next;
    logic          wr_time;

    assign wr_time = wr_en && !addr[1];
    assign t_next  = {t_hi, t_lo} + TW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_lo <= '0;
        t_hi <= '0;
        c_lo <= '0;
        c_hi <= '0;
      end else begin
        if (wr_time) begin
          if (addr[0]) t_hi <= wr_data;
          else         t_lo <= wr_data;
        end else if (tick_en) begin
          {t_hi, t_lo} <= t_next;
        end
        if (wr_en && addr == 2'd2) c_lo <= wr_data;
        if (wr_en && addr == 2'd3) c_hi <= wr_data;
      end
    end

    always_comb begin
      case (addr)
        2'd0:    rd_data = t_lo;
        2'd1:    rd_data = t_hi;
        2'd2:    rd_data = c_lo;
        default: rd_data = c_hi;
      endcase
    end

    assign time_now = {t_hi, t_lo};
    assign tmr_irq  = {t_hi, t_lo} >= {c_hi, c_lo};

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_time) |=> ({t_hi, t_lo} == $past({t_hi, t_lo}) + TW'(1)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_time) |=> $stable({t_hi, t_lo}));
    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !wr_time && t_lo == '1) |=> (t_lo == '0 && t_hi == $past(t_hi) + DW'(1)));
    p_wrlo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0) |=> (t_lo == $past(wr_data) && $stable(t_hi)));
    p_wrhi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1) |=> (t_hi == $past(wr_data) && $stable(t_lo)));
    p_cmp_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr[1]) |=> $stable({c_hi, c_lo}));
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_irq && !wr_en && time_now != '1) |=> tmr_irq);
  end else begin : g_absent
    assign rd_data  = '0;
    assign time_now = '0;
    assign tmr_irq  = ext_irq;
  end
endmodule

// File: tb/sys_timer64_test.sv
`timescale 1ns/1ps
module sys_timer64_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic        ext_irq = 1'b0;
  logic [31:0] rd_data, rd_data_b;
  logic [63:0] time_now, time_now_b;
  logic        tmr_irq, tmr_irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sys_timer64 uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ext_irq(ext_irq),
    .time_now(time_now), .tmr_irq(tmr_irq));

  sys_timer64 #(.PRESENT(1'b0)) uut_absent (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data_b), .ext_irq(ext_irq),
    .time_now(time_now_b), .tmr_irq(tmr_irq_b));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic read64(input logic [1:0] base, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(base, lo);
    rd(base + 2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  function automatic logic [63:0] grid(input int k);
    logic [31:0] lo, hi;
    lo = (k % 3 == 0) ? 32'h0 : (k % 3 == 1) ? 32'h1 : 32'hFFFF_FFFF;
    hi = 32'(k / 3);
    return {hi, lo};
  endfunction

  initial begin
    logic [63:0] v;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 time", time_now, 64'h0);
    check("R1 irq", {63'h0, tmr_irq}, 64'h1);
    read64(2'd2, v);
    check("R1 cmp", v, 64'h0);

    // R2 increment and hold, R8 mirror
    run(37);
    read64(2'd0, v);
    check("R2 count", v, 64'd37);
    check("R8 time_now", time_now, 64'd37);
    repeat (5) @(negedge clk);
    check("R2 hold", time_now, 64'd37);

    // R3 carry
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'h0000_0005);
    run(1);
    check("R3 pre", time_now, 64'h0000_0005_FFFF_FFFF);
    run(1);
    read64(2'd0, v);
    check("R3 carry", v, 64'h0000_0006_0000_0000);
    run(3);
    check("R3 after", time_now, 64'h0000_0006_0000_0003);

    // R4 write vs increment in same cycle
    wr(2'd1, 32'h0000_0003);
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 2'd0; wr_data = 32'd10;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    check("R4 lo write wins", time_now, 64'h0000_0003_0000_000A);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 2'd1; wr_data = 32'h77;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    check("R4 hi write wins", time_now, 64'h0000_0077_0000_000A);

    // R5 / R9 compare halves and word map
    wr(2'd2, 32'hAAAA_5555);
    wr(2'd3, 32'h1234_5678);
    rd(2'd2, w); check("R9 cmp lo", {32'h0, w}, 64'hAAAA_5555);
    rd(2'd3, w); check("R9 cmp hi", {32'h0, w}, 64'h1234_5678);
    wr(2'd2, 32'h0000_0001);
    read64(2'd2, v);
    check("R5 half write", v, 64'h1234_5678_0000_0001);
    run(4);
    read64(2'd2, v);
    check("R5 cmp stable", v, 64'h1234_5678_0000_0001);
    rd(2'd1, w); check("R9 time hi", {32'h0, w}, 64'h77);

    // R6 comparator sweep
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        logic [63:0] tv, cv;
        tv = grid(i); cv = grid(j);
        wr(2'd0, tv[31:0]); wr(2'd1, tv[63:32]);
        wr(2'd2, cv[31:0]); wr(2'd3, cv[63:32]);
        #1;
        check("R6 compare", {63'h0, tmr_irq}, {63'h0, tv >= cv});
      end
    end

    // R7 level holding and clearing
    wr(2'd3, 32'h0); wr(2'd2, 32'd100);
    wr(2'd1, 32'h0); wr(2'd0, 32'd100);
    #1 check("R7 set", {63'h0, tmr_irq}, 64'h1);
    run(20);
    check("R7 held", {63'h0, tmr_irq}, 64'h1);
    wr(2'd3, 32'h1);
    #1 check("R7 clr by cmp", {63'h0, tmr_irq}, 64'h0);
    wr(2'd3, 32'h0);
    #1 check("R7 reassert", {63'h0, tmr_irq}, 64'h1);
    wr(2'd0, 32'd5);
    #1 check("R7 clr by time", {63'h0, tmr_irq}, 64'h0);
    run(95);
    check("R7 reach cmp", {63'h0, tmr_irq}, 64'h1);

    // R10 absent variant
    ext_irq = 1'b1;
    #1 check("R10 irq high", {63'h0, tmr_irq_b}, 64'h1);
    ext_irq = 1'b0;
    #1 check("R10 irq low", {63'h0, tmr_irq_b}, 64'h0);
    check("R10 time", time_now_b, 64'h0);
    check("R10 read", {32'h0, rd_data_b}, 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule